// File: doc/BRIEF.md
# Serial Audio Transmitter (I2S / PCM master)

This block is a master-mode serial audio transmitter. It divides a kernel clock down to a bit clock, generates a word-select or frame-sync line, and shifts parallel sample words out MSB first on a serial data line. Samples arrive through a one-entry holding register with a valid/ready handshake. Each channel slot takes one sample from the holding register.

A set of configuration inputs is sampled continuously and is expected to stay constant while reset is released. These inputs choose the framing standard, the slot and sample widths, the bit clock polarity, the word-select polarity, the PCM sync length and how a sample sits inside the 32-bit input word. After reset the frame counter starts at the first bit of a left (or PCM) slot. That first slot carries zeros, and the first accepted sample goes out in the second slot.

Top module: `audio_ser_tx`

## Requirements
- R1: One bit period lasts 2*D + O kernel cycles, where D is `cfg_div` (a value of 0 is treated as 1) and O is `cfg_odd`. Counted from the start of the period, the unpolarised bit clock is low for D + O cycles and then high for D cycles.
- R2: `sck` is the unpolarised bit clock XOR `cfg_ckpol`. `sd` and `ws` change only at the start of a bit period, so with polarity 0 they change on the falling edge of `sck`, and with polarity 1 on the rising edge.
- R3: A slot is 16 bits when `cfg_wide_ch`=0 and 32 bits when it is 1. It is also 32 bits whenever `cfg_dlen` is not 0.
- R4: `cfg_dlen` selects the sample width: 0 gives 16 bits, 1 gives 24 bits, and 2 or 3 give 32 bits. Samples go out MSB first, and every slot bit outside the sample is 0.
- R5: With `cfg_left`=0 the sample is taken from bits [W-1:0] of the input word. With `cfg_left`=1 it is taken from bits [31:32-W]. The remaining bits of the word have no effect on `sd`.
- R6: With `cfg_std`=0 (Philips), word select (before inversion) is 0 for the left slot and 1 for the right slot. It changes one bit period before the MSB of the slot.
- R7: With `cfg_std`=1 (MSB-justified), word select changes in the same bit period as the MSB, which is the first bit of the slot.
- R8: With `cfg_std`=2 (LSB-justified), word select follows the slot as in R7. The sample LSB is on the last bit of the slot, and zeros fill the bits before the sample.
- R9: With `cfg_std`=3 (PCM), a frame is a single slot. With `cfg_pcm_long`=0 the sync is high only in the bit period before the MSB. With `cfg_pcm_long`=1 it is high for 13 bit periods, starting with the MSB.
- R10: `cfg_wsinv`=1 inverts the `ws` output.
- R11: `smp_ready` is high exactly when the holding register is empty. An accepted sample is held until the next slot starts, and slots use samples in acceptance order. A slot that starts with the holding register empty sends zeros.
- R12: During reset `sd`=0 and `smp_ready`=1. Frame position 0 is presented, so `ws` is 0 (before inversion) in the Philips and justified standards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_div | input | DIV_W | Linear divide value D |
| cfg_odd | input | 1 | Adds one kernel cycle to the bit period |
| cfg_std | input | 2 | Framing standard: 0 Philips, 1 MSB-justified, 2 LSB-justified, 3 PCM |
| cfg_wide_ch | input | 1 | Slot width: 0 = 16 bits, 1 = 32 bits |
| cfg_dlen | input | 2 | Sample width: 0 = 16, 1 = 24, 2/3 = 32 |
| cfg_ckpol | input | 1 | Bit clock polarity |
| cfg_wsinv | input | 1 | Word-select output inversion |
| cfg_pcm_long | input | 1 | PCM sync: 0 = one bit, 1 = 13 bits |
| cfg_left | input | 1 | Sample position in the word: 0 = low bits, 1 = high bits |
| smp_data | input | 32 | Sample word |
| smp_valid | input | 1 | Sample word offered |
| smp_ready | output | 1 | Holding register empty |
| sck | output | 1 | Bit clock |
| ws | output | 1 | Word select / frame sync |
| sd | output | 1 | Serial data |

## Verification
Each fault in the frame or bit counter shows up at the ports in a specific way. A slipped frame position moves a `ws` transition relative to the MSB on `sd`, and that error is visible within one bit period. A miscounted prescaler changes the number of kernel cycles between `sck` edges within the first bit. An incorrect holding-register flag shows immediately on `smp_ready`: it either stays high after an accept or never rises again after a slot start. An alignment fault or a padding fault shows as wrong `sd` bits in the first slot that carries a sample, which is the second slot after reset. The bench compares every kernel cycle of several frames against a model of the serial stream built from the requirements.

// File: rtl/audio_ser_tx.sv
module audio_ser_tx #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_odd,
  input  logic [1:0]       cfg_std,
  input  logic             cfg_wide_ch,
  input  logic [1:0]       cfg_dlen,
  input  logic             cfg_ckpol,
  input  logic             cfg_wsinv,
  input  logic             cfg_pcm_long,
  input  logic             cfg_left,
  input  logic [31:0]      smp_data,
  input  logic             smp_valid,
  output logic             smp_ready,
  output logic             sck,
  output logic             ws,
  output logic             sd
);
  localparam int CW = DIV_W + 1;

  logic [DIV_W-1:0] div_eff;
  logic [CW-1:0]    ratio, low_len, cnt;
  logic [5:0]       b, b_nx, flen_m1, slen, dlen, lead, rel;
  logic [4:0]       p, p_nx;
  logic             wide, pcm, tick, slot_go, full, ch, ch_nx, ws_raw, in_data;
  logic [31:0]      hold, cur, aligned;

  assign div_eff = (cfg_div == '0) ? DIV_W'(1) : cfg_div;
  assign ratio   = {div_eff, cfg_odd};
  assign low_len = ratio - CW'(div_eff);
  assign tick    = (cnt >= ratio - CW'(1));

  assign wide    = cfg_wide_ch | (cfg_dlen != 2'd0);
  assign pcm     = (cfg_std == 2'd3);
  assign slen    = wide ? 6'd32 : 6'd16;
  assign flen_m1 = pcm ? slen - 6'd1 : (wide ? 6'd63 : 6'd31);
  assign b_nx    = (b >= flen_m1) ? 6'd0 : b + 6'd1;
  assign p       = wide ? b[4:0] : {1'b0, b[3:0]};
  assign p_nx    = wide ? b_nx[4:0] : {1'b0, b_nx[3:0]};
  assign ch      = wide ? b[5] : b[4];
  assign ch_nx   = wide ? b_nx[5] : b_nx[4];
  assign slot_go = tick && (p_nx == 5'd0);

  assign dlen    = (cfg_dlen == 2'd0) ? 6'd16 : (cfg_dlen == 2'd1) ? 6'd24 : 6'd32;
  assign lead    = (cfg_std == 2'd2) ? slen - dlen : 6'd0;
  assign rel     = {1'b0, p} - lead;
  assign in_data = ({1'b0, p} >= lead) && (rel < dlen);
  assign aligned = cfg_left ? hold : (hold << (6'd32 - dlen));

  always_comb begin
    case (cfg_std)
      2'd0:    ws_raw = ch_nx;
      2'd3:    ws_raw = cfg_pcm_long ? (b < 6'd13) : (b == flen_m1);
      default: ws_raw = ch;
    endcase
  end

  assign ws        = ws_raw ^ cfg_wsinv;
  assign sd        = in_data & cur[5'd31 - rel[4:0]];
  assign sck       = (cnt >= low_len) ^ cfg_ckpol;
  assign smp_ready = ~full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      b    <= '0;
      full <= 1'b0;
      hold <= '0;
      cur  <= '0;
    end else begin
      cnt <= tick ? '0 : cnt + CW'(1);
      if (tick) b <= b_nx;
      if (slot_go) cur <= full ? aligned : '0;
      if (smp_valid && !full) hold <= smp_data;
      full <= (full & ~slot_go) | (smp_valid & ~full);
    end
  end
endmodule

// File: rtl/audio_ser_tx_chk.sv
module audio_ser_tx_chk #(
  parameter int CW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] cnt,
  input logic [4:0]    slot_pos,
  input logic [1:0]    std,
  input logic          ckpol,
  input logic          sck,
  input logic          ws,
  input logic          sd,
  input logic          smp_valid,
  input logic          smp_ready
);
  assert_hold_full_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready) |=> !smp_ready);

  assert_bit_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> ($stable(sd) && $stable(ws)));

  assert_change_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sd) || !$stable(ws)) |-> (sck == ckpol));

  assert_msbj_ws_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (std == 2'd1 && !$stable(ws)) |-> (slot_pos == 5'd0));
endmodule

bind audio_ser_tx audio_ser_tx_chk #(.CW(DIV_W + 1)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt), .slot_pos(p), .std(cfg_std),
  .ckpol(cfg_ckpol), .sck(sck), .ws(ws), .sd(sd),
  .smp_valid(smp_valid), .smp_ready(smp_ready)
);

// File: tb/audio_ser_tx_tb_top.sv
module audio_ser_tx_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] cfg_div = 8'd1;
  logic cfg_odd = 1'b0, cfg_wide_ch = 1'b0, cfg_ckpol = 1'b0, cfg_wsinv = 1'b0;
  logic cfg_pcm_long = 1'b0, cfg_left = 1'b0, smp_valid = 1'b0;
  logic [1:0] cfg_std = 2'd0, cfg_dlen = 2'd0;
  logic [31:0] smp_data = '0;
  logic smp_ready, sck, ws, sd;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  audio_ser_tx #(.DIV_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_odd(cfg_odd), .cfg_std(cfg_std),
    .cfg_wide_ch(cfg_wide_ch), .cfg_dlen(cfg_dlen), .cfg_ckpol(cfg_ckpol),
    .cfg_wsinv(cfg_wsinv), .cfg_pcm_long(cfg_pcm_long), .cfg_left(cfg_left),
    .smp_data(smp_data), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .sck(sck), .ws(ws), .sd(sd));

  // {div, odd, std, wide, dlen, ckpol, wsinv, pcm_long, left}
  localparam logic [17:0] VEC [8] = '{
    {8'd1, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},  // R6 Philips 16/16
    {8'd2, 1'b1, 2'd1, 1'b1, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1},  // R7 32 in 32, pol 1
    {8'd1, 1'b1, 2'd2, 1'b1, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0},  // R8 24 in 32, inverted
    {8'd2, 1'b0, 2'd3, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1},  // R9 short sync
    {8'd1, 1'b0, 2'd3, 1'b1, 2'd1, 1'b1, 1'b0, 1'b1, 1'b1},  // R9 long sync
    {8'd0, 1'b1, 2'd0, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0},  // R3 24 forces 32 slot, div 0
    {8'd7, 1'b1, 2'd2, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1},  // R1 ratio 15, R8 16/16
    {8'd1, 1'b0, 2'd1, 1'b0, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0}   // R4 code 3 as 32
  };

  function automatic logic [31:0] samp(int v, int n);
    return (32'(n + 3) * 32'h9E3779B9) ^ {8'(v * 17), 24'h5A0C3};
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic apply(logic [17:0] v);
    rst_n = 1'b0;
    smp_valid = 1'b0;
    cfg_left = v[0]; cfg_pcm_long = v[1]; cfg_wsinv = v[2]; cfg_ckpol = v[3];
    cfg_dlen = v[5:4]; cfg_wide_ch = v[6]; cfg_std = v[8:7]; cfg_odd = v[9];
    cfg_div = v[17:10];
    repeat (2) @(negedge clk);
  endtask

  task automatic run_vec(int vi, logic [17:0] v, bit feed, int slots);
    int de, n, lo, dw, sl, fl, fidx;
    bit took;
    string stag;
    apply(v);
    rst_n = 1'b1;
    de = (v[17:10] == 0) ? 1 : int'(v[17:10]);
    n  = 2 * de + int'(v[9]);
    lo = de + int'(v[9]);
    dw = (v[5:4] == 0) ? 16 : (v[5:4] == 1) ? 24 : 32;
    sl = (v[6] || v[5:4] != 0) ? 32 : 16;
    fl = (v[8:7] == 3) ? sl : 2 * sl;
    stag = (v[8:7] == 0) ? "R6" : (v[8:7] == 1) ? "R7" : (v[8:7] == 2) ? "R8" : "R9";
    fidx = 0;
    took = 0;
    for (int k = 0; k < slots * sl; k++) begin
      int s, p, b, lead;
      logic [31:0] word, al;
      logic esd, ews;
      s = k / sl; p = k % sl; b = k % fl;
      word = (s == 0 || !feed) ? 32'h0 : samp(vi, s - 1);
      al = v[0] ? word : (word << (32 - dw));
      lead = (v[8:7] == 2) ? sl - dw : 0;
      esd = (p >= lead && p - lead < dw) ? al[31 - (p - lead)] : 1'b0;
      case (v[8:7])
        2'd0:    ews = (((b + 1) % fl) >= sl);
        2'd3:    ews = v[1] ? (b < 13) : (b == fl - 1);
        default: ews = (b >= sl);
      endcase
      ews = ews ^ v[2];
      for (int j = 0; j < n; j++) begin
        chk(sd === esd, {stag, "/R3/R4/R5/R11 sd"}, 32'(sd), 32'(esd));
        chk(ws === ews, {stag, "/R10 ws"}, 32'(ws), 32'(ews));
        chk(sck === ((j >= lo) ^ v[3]), "R1/R2 sck", 32'(sck), 32'((j >= lo) ^ v[3]));
        if (took) fidx++;
        smp_valid = feed;
        smp_data = samp(vi, fidx);
        took = feed && smp_ready;
        @(negedge clk);
      end
    end
    smp_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R11 actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R12 reset state, Philips, no inversion
    apply(VEC[0]);
    chk(sd === 1'b0, "R12 sd in reset", 32'(sd), 0);
    chk(smp_ready === 1'b1, "R12 ready in reset", 32'(smp_ready), 1);
    chk(ws === 1'b0, "R12 ws in reset", 32'(ws), 0);
    chk(sck === 1'b0, "R12 sck in reset", 32'(sck), 0);
    // R10 inversion visible at frame position 0
    apply(VEC[2]);
    chk(ws === 1'b1, "R10 ws inverted in reset", 32'(ws), 1);

    for (int i = 0; i < 8; i++) run_vec(i, VEC[i], 1'b1, 4);

    // R11 underrun: no samples offered, every slot is zero
    run_vec(9, VEC[1], 1'b0, 3);

    // R11 holding register full drops ready until the next slot start
    apply(VEC[1]);
    rst_n = 1'b1;
    smp_valid = 1'b1;
    smp_data = 32'hDEAD_BEEF;
    @(negedge clk);
    smp_valid = 1'b0;
    chk(smp_ready === 1'b0, "R11 ready low when held", 32'(smp_ready), 0);
    repeat (20) @(negedge clk);
    chk(smp_ready === 1'b0, "R11 ready stays low mid slot", 32'(smp_ready), 0);
    // slot 1 starts 32 bits * 5 cycles after release
    repeat (32 * 5 - 21) @(negedge clk);
    chk(smp_ready === 1'b1, "R11 ready after slot start", 32'(smp_ready), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule